// File: doc/BRIEF.md
# Watchpoint Address Range Decoder

This block holds the four debug registers for one data watchpoint and one instruction breakpoint. It turns their raw fields into a usable form: an effective watched base address, a byte length and a read/write enable pair for the watchpoint, and an effective instruction address for the breakpoint. A write goes into the register selected by `wr_sel`. From the next cycle on, the decoded outputs reflect the new contents.

A combinational comparator takes one memory access, given as address, byte size and direction. It raises a hit when the bytes of the access overlap the watched bytes and that direction is being watched. The watched range has two possible sources. One is a power-of-two mask that aligns the base downward. The other is the first contiguous run of set bits in an 8-bit byte-select field, counted from the value register. Reserved encodings leave the watchpoint inactive.

Top module: `wp_range_decoder`

## Requirements
- R1: After reset, all four registers are zero, so `wp_valid`, `bp_valid` and `acc_hit` are all 0.
- R2: The watch control uses these fields: enable at bit 0, direction code at bits [4:3], byte select at bits [12:5] and mask at bits [28:24]. The watchpoint is inactive when the enable is 0 or the direction code is 0. Codes 1, 2 and 3 give `wp_rw` values 01 (reads), 10 (writes) and 11 (both). In `wp_rw`, bit 0 stands for reads and bit 1 for writes.
- R3: Mask values 1 and 2 make the watchpoint inactive. A mask M of 3 or more gives `wp_len` = 2^M and a `wp_base` whose low M bits are zero, whatever the byte select holds.
- R4: With mask 0, a byte select of zero makes the watchpoint inactive. Otherwise `wp_base` is the watch value plus the index of the lowest set byte-select bit, and `wp_len` is the length of the run of ones that starts there. Ones after that run are ignored.
- R5: With mask 0 and bit 2 of the watch value set, only byte-select bits [3:0] count.
- R6: A write to the watch value register stores zero in bits [1:0].
- R7: A write to the break control stores byte-select bit 0 (bit 5) into bit 1 (bit 6), and bit 2 (bit 7) into bit 3 (bit 8). The only codes that can be held are therefore 0000, 0011, 1100 and 1111. `bp_addr` is the break value with bits [1:0] cleared, plus 2 when the code is 1100.
- R8: `bp_valid` is 1 only when the enable (bit 0) is 1, the type field (bits [23:20]) is 0 or 1, and the byte select is nonzero.
- R9: `acc_hit` is 1 when `acc_valid` is high, `acc_size` is nonzero, the watchpoint is active, the direction given by `acc_write` is enabled in `wp_rw`, and the range [`acc_addr`, `acc_addr`+`acc_size`) overlaps [`wp_base`, `wp_base`+`wp_len`).
- R10: Decoded outputs keep their old values until the clock edge that takes a write, and show the new decode right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 watch value, 1 watch control, 2 break value, 3 break control |
| wr_data | input | AW | Write data (control registers use the low 32 bits) |
| wp_valid | output | 1 | Watchpoint decodes to an active range |
| wp_base | output | AW | First watched byte address |
| wp_len | output | AW+1 | Number of watched bytes |
| wp_rw | output | 2 | Watched directions: bit 0 read, bit 1 write |
| bp_valid | output | 1 | Breakpoint decodes to an active address match |
| bp_addr | output | AW | Effective breakpoint instruction address |
| acc_valid | input | 1 | Access to compare is present |
| acc_addr | input | AW | Access start byte address |
| acc_size | input | SW | Access size in bytes |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_hit | output | 1 | Access matches the watchpoint |

## Verification
The bench targets several decode rules that are easy to get wrong.

- Mask values 1 and 2 must disable the watchpoint. A decoder that treats them as small masks produces a 2- or 4-byte range.
- A byte-select value with a gap must be cut at the gap. Counting every set bit makes the length too long.
- When value bit 2 is set, the upper byte-select nibble must be dropped. Keeping it enables bytes that should not be watched.
- The break-control bit copies must be applied on write. Without them, a lone bit 2 never becomes 1100, so the +2 offset is lost.

The comparator is driven with accesses that end one byte before the range, start on its last byte, and start just past it. An off-by-one in either bound shows up as a wrong hit at one of these edges. Direction masking and zero-size accesses are also checked.

// File: rtl/wp_range_decoder.sv
module wp_range_decoder #(
  parameter int AW = 32,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic          wp_valid,
  output logic [AW-1:0] wp_base,
  output logic [AW:0]   wp_len,
  output logic [1:0]    wp_rw,
  output logic          bp_valid,
  output logic [AW-1:0] bp_addr,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [SW-1:0] acc_size,
  input  logic          acc_write,
  output logic          acc_hit
);
  logic [AW-1:0] w_val;
  logic          w_en;
  logic [1:0]    w_dir;
  logic [7:0]    w_sel;
  logic [4:0]    w_msk;
  logic [AW-3:0] b_val;
  logic          b_en;
  logic [3:0]    b_type;
  logic [3:0]    b_sel;

  logic unused_wr;
  assign unused_wr = ^{wr_data[AW-1:29], wr_data[23:13], wr_data[19:9], wr_data[4:1], wr_data[6], wr_data[8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_val  <= '0;
      w_en   <= 1'b0;
      w_dir  <= 2'b00;
      w_sel  <= 8'h00;
      w_msk  <= 5'd0;
      b_val  <= '0;
      b_en   <= 1'b0;
      b_type <= 4'd0;
      b_sel  <= 4'd0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: w_val <= {wr_data[AW-1:2], 2'b00};
        2'd1: begin
          w_en  <= wr_data[0];
          w_dir <= wr_data[4:3];
          w_sel <= wr_data[12:5];
          w_msk <= wr_data[28:24];
        end
        2'd2: b_val <= wr_data[AW-1:2];
        default: begin
          b_en   <= wr_data[0];
          b_type <= wr_data[23:20];
          b_sel  <= {wr_data[7], wr_data[7], wr_data[5], wr_data[5]};
        end
      endcase
    end
  end

  logic [7:0] sel_eff;
  logic [2:0] first;
  logic [3:0] run;
  logic       found, going;

  assign sel_eff = w_val[2] ? {4'h0, w_sel[3:0]} : w_sel;

  always_comb begin
    first = 3'd0;
    found = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!found && sel_eff[i]) begin
        first = 3'(i);
        found = 1'b1;
      end
    end
    run   = 4'd0;
    going = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (3'(i) >= first) begin
        if (going && sel_eff[i]) run = run + 4'd1;
        else going = 1'b0;
      end
    end
  end

  logic          use_mask;
  logic [AW:0]   mask_len;
  assign use_mask = (w_msk != 5'd0);
  assign mask_len = {{AW{1'b0}}, 1'b1} << w_msk;

  assign wp_valid = w_en && (w_dir != 2'b00) &&
                    (use_mask ? (w_msk != 5'd1 && w_msk != 5'd2) : (sel_eff != 8'h00));
  assign wp_rw    = wp_valid ? w_dir : 2'b00;
  assign wp_len   = use_mask ? mask_len : {{(AW-3){1'b0}}, run};
  assign wp_base  = use_mask ? (w_val & ~(mask_len[AW-1:0] - 1'b1))
                             : (w_val + {{(AW-3){1'b0}}, first});

  assign bp_valid = b_en && (b_type == 4'd0 || b_type == 4'd1) && (b_sel != 4'd0);
  assign bp_addr  = {b_val, 2'b00} + ((b_sel == 4'b1100) ? AW'(2) : AW'(0));

  logic [AW:0] acc_end, wp_end;
  assign acc_end = {1'b0, acc_addr} + {{(AW+1-SW){1'b0}}, acc_size};
  assign wp_end  = {1'b0, wp_base} + wp_len;

  assign acc_hit = acc_valid && wp_valid && (acc_size != '0) &&
                   (acc_write ? wp_rw[1] : wp_rw[0]) &&
                   ({1'b0, acc_addr} < wp_end) && ({1'b0, wp_base} < acc_end);
endmodule

// File: rtl/wp_range_decoder_chk.sv
module wp_range_decoder_chk #(
  parameter int AW = 32,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wp_valid,
  input logic [AW-1:0] wp_base,
  input logic [AW:0]   wp_len,
  input logic [1:0]    wp_rw,
  input logic          bp_valid,
  input logic [AW-1:0] bp_addr,
  input logic          acc_valid,
  input logic [SW-1:0] acc_size,
  input logic          acc_hit
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!wp_valid && !bp_valid && !acc_hit));

  assert_dir_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wp_valid |-> (wp_rw != 2'b00));

  assert_mask_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_valid && wp_len > (AW+1)'(8)) |->
      ($countones(wp_len) == 1 && (wp_base & (wp_len[AW-1:0] - 1'b1)) == '0));

  assert_len_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wp_valid |-> (wp_len != '0));

  assert_bp_halfword_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bp_valid |-> (bp_addr[0] == 1'b0));

  assert_hit_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> (acc_valid && wp_valid && acc_size != '0));

  assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en)) |->
      ($stable(wp_base) && $stable(wp_len) && $stable(wp_rw) && $stable(bp_addr) && $stable(bp_valid)));
endmodule

bind wp_range_decoder wp_range_decoder_chk #(.AW(AW), .SW(SW)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wp_valid(wp_valid), .wp_base(wp_base),
  .wp_len(wp_len), .wp_rw(wp_rw), .bp_valid(bp_valid), .bp_addr(bp_addr),
  .acc_valid(acc_valid), .acc_size(acc_size), .acc_hit(acc_hit)
);

// File: tb/test_wp_range_decoder.sv
module test_wp_range_decoder;
  localparam int AW = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [AW-1:0] wr_data = '0;
  logic wp_valid, bp_valid, acc_hit;
  logic [AW-1:0] wp_base, bp_addr;
  logic [AW:0] wp_len;
  logic [1:0] wp_rw;
  logic acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [SW-1:0] acc_size = '0;
  logic acc_write = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wp_range_decoder #(.AW(AW), .SW(SW)) i_wp_range_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wp_valid(wp_valid), .wp_base(wp_base), .wp_len(wp_len), .wp_rw(wp_rw),
    .bp_valid(bp_valid), .bp_addr(bp_addr), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_write(acc_write), .acc_hit(acc_hit)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wctl(bit en, logic [1:0] dir, logic [7:0] sel, logic [4:0] msk);
    return {3'b0, msk, 11'b0, sel, dir, 2'b0, en};
  endfunction

  function automatic logic [31:0] bctl(bit en, logic [3:0] typ, logic [3:0] sel);
    return {8'b0, typ, 11'b0, sel, 4'b0, en};
  endfunction

  task automatic wr(logic [1:0] sel, logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 wp_valid", wp_valid, 0);
    chk("R1 bp_valid", bp_valid, 0);
    acc_valid = 1; acc_size = 4; #1;
    chk("R1 acc_hit", acc_hit, 0);
    acc_valid = 0;
  endtask

  task automatic t_dir();
    wr(0, 32'h1000);
    wr(1, wctl(1, 2'd1, 8'h0F, 0));
    chk("R2 valid code1", wp_valid, 1);
    chk("R2 rw code1", wp_rw, 2'b01);
    chk("R4 base", wp_base, 32'h1000);
    chk("R4 len", wp_len, 4);
    wr(1, wctl(1, 2'd2, 8'h0F, 0));
    chk("R2 rw code2", wp_rw, 2'b10);
    wr(1, wctl(1, 2'd3, 8'h0F, 0));
    chk("R2 rw code3", wp_rw, 2'b11);
    wr(1, wctl(1, 2'd0, 8'h0F, 0));
    chk("R2 code0 inactive", wp_valid, 0);
    wr(1, wctl(0, 2'd3, 8'h0F, 0));
    chk("R2 enable clear", wp_valid, 0);
  endtask

  task automatic t_mask();
    wr(0, 32'h12345);
    wr(1, wctl(1, 2'd3, 8'h00, 5'd1));
    chk("R3 mask1 inactive", wp_valid, 0);
    wr(1, wctl(1, 2'd3, 8'h00, 5'd2));
    chk("R3 mask2 inactive", wp_valid, 0);
    wr(1, wctl(1, 2'd3, 8'h00, 5'd12));
    chk("R3 mask12 valid", wp_valid, 1);
    chk("R3 mask12 base", wp_base, 32'h12000);
    chk("R3 mask12 len", wp_len, 33'h1000);
    wr(1, wctl(1, 2'd3, 8'h07, 5'd3));
    chk("R3 mask3 base", wp_base, 32'h12340);
    chk("R3 mask3 len", wp_len, 8);
  endtask

  task automatic t_bytesel();
    wr(0, 32'h8000);
    wr(1, wctl(1, 2'd1, 8'b0011_1000, 0));
    chk("R4 run base", wp_base, 32'h8003);
    chk("R4 run len", wp_len, 3);
    wr(1, wctl(1, 2'd1, 8'b1101_1000, 0));
    chk("R4 gap base", wp_base, 32'h8003);
    chk("R4 gap len", wp_len, 2);
    wr(1, wctl(1, 2'd1, 8'h00, 0));
    chk("R4 zero inactive", wp_valid, 0);
  endtask

  task automatic t_bit2();
    wr(0, 32'h2004);
    wr(1, wctl(1, 2'd1, 8'hF0, 0));
    chk("R5 upper nibble dropped", wp_valid, 0);
    wr(1, wctl(1, 2'd1, 8'hF6, 0));
    chk("R5 base", wp_base, 32'h2005);
    chk("R5 len", wp_len, 2);
  endtask

  task automatic t_lowbits();
    wr(0, 32'h3003);
    wr(1, wctl(1, 2'd1, 8'h01, 0));
    chk("R6 base low bits", wp_base, 32'h3000);
    chk("R6 len", wp_len, 1);
  endtask

  task automatic t_bp();
    wr(2, 32'h4003);
    wr(3, bctl(1, 4'd0, 4'b0001));
    chk("R7 code0011 valid", bp_valid, 1);
    chk("R7 code0011 addr", bp_addr, 32'h4000);
    wr(3, bctl(1, 4'd0, 4'b0100));
    chk("R7 code1100 addr", bp_addr, 32'h4002);
    wr(3, bctl(1, 4'd1, 4'b0101));
    chk("R7 code1111 addr", bp_addr, 32'h4000);
    chk("R8 type1 valid", bp_valid, 1);
    wr(3, bctl(1, 4'd0, 4'b0000));
    chk("R8 sel0 inactive", bp_valid, 0);
    wr(3, bctl(1, 4'd2, 4'b0101));
    chk("R8 type2 inactive", bp_valid, 0);
    wr(3, bctl(0, 4'd0, 4'b0101));
    chk("R8 enable clear", bp_valid, 0);
  endtask

  task automatic t_hit();
    wr(0, 32'h1000);
    wr(1, wctl(1, 2'd1, 8'h0F, 0));
    acc_valid = 1; acc_write = 0;
    acc_addr = 32'h0FFE; acc_size = 2; #1;
    chk("R9 ends before range", acc_hit, 0);
    acc_addr = 32'h0FFF; #1;
    chk("R9 overlaps first byte", acc_hit, 1);
    acc_addr = 32'h1003; acc_size = 1; #1;
    chk("R9 last byte", acc_hit, 1);
    acc_addr = 32'h1004; #1;
    chk("R9 past range", acc_hit, 0);
    acc_addr = 32'h1000; acc_write = 1; #1;
    chk("R9 write not watched", acc_hit, 0);
    acc_write = 0; acc_size = 0; #1;
    chk("R9 zero size", acc_hit, 0);
    acc_size = 4; acc_valid = 0; #1;
    chk("R9 no access", acc_hit, 0);
    acc_valid = 0;
  endtask

  task automatic t_timing();
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd0; wr_data = 32'h5000; #1;
    chk("R10 old before edge", wp_base, 32'h1000);
    @(negedge clk);
    wr_en = 0;
    chk("R10 new after edge", wp_base, 32'h5000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dir();
    t_mask();
    t_bytesel();
    t_bit2();
    t_lowbits();
    t_bp();
    t_hit();
    t_timing();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule